// File: doc/BRIEF.md
# Interrupt-capable 32-pin GPIO port

This block is a 32-pin general-purpose I/O port with its own interrupt logic. Software reaches it over a plain 32-bit register bus: a word address, a write strobe, write data, and read data that is valid in the same cycle. Each pin is an input or an output. Output pins drive the value held in the output data register. All pad levels pass through a two-stage synchronizer and can be read back as a status word.

Each pin can raise an interrupt on one of these conditions: a low level, a high level, a rising edge, a falling edge, or any edge. A captured event sets a sticky status bit. Software clears the bit by writing a one to it. A per-pin enable gates each status bit onto one of two request lines. One line serves the lower sixteen pins and the other serves the upper sixteen.

Top module: `pin_port_irq`

## Requirements
- R1: The registers sit at these byte offsets: output data 0x00, direction 0x04, trigger code for pins 0–15 at 0x0C, trigger code for pins 16–31 at 0x10, enable 0x14, event status 0x18, any-edge select 0x1C. Each reads back the last value written to it. Reading the output data register returns that stored value, never the pad level.
- R2: pad_out always equals the output data register. Bit p of pad_oe equals bit p of the direction register, so 1 means output and 0 means input.
- R3: A read at offset 0x08 returns pad_in as it was two rising clock edges earlier. Writes to 0x08 have no effect.
- R4: The 2-bit trigger code of pin p sits at bits 2·(p mod 16)+1 : 2·(p mod 16). For p < 16 it is in the word at 0x0C, otherwise in the word at 0x10.
- R5: The trigger codes are: 00 means the synchronized level is low, 01 means it is high, 10 means it went 0→1 since the previous synchronized sample, and 11 means it went 1→0. For an edge, the status bit reads 1 after the third rising clock edge that follows the pad change.
- R6: When bit p of the any-edge select register is 1, pin p triggers on both transitions and its trigger code is ignored.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. If an event and a clear hit the same bit in one cycle, the bit stays set.
- R8: A level-triggered pin sets its status bit in every cycle its level holds, so the bit reappears at once after a clear.
- R9: irq_lo is the OR of status AND enable over pins 0–15. irq_hi is the same over pins 16–31.
- R10: After reset, the data, direction, trigger code, enable and any-edge registers read zero, pad_oe is zero, and both request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte address bits 4:2 |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 32 | Pad levels, asynchronous |
| pad_out | output | 32 | Output value to pads |
| pad_oe | output | 32 | Output enable per pad |
| irq_lo | output | 1 | Request for pins 0–15 |
| irq_hi | output | 1 | Request for pins 16–31 |

## Verification
Suppose the previous-sample register or the per-pin trigger decode holds a wrong value. The status word then shows a missing or extra bit three clocks after the stimulating pad change. The request line of that half of the port shows the same error when the pin is enabled. Suppose instead that a clear or a stale sticky bit goes wrong. That shows up on the status read in the cycle right after the write, and a level-mode pin reasserts at once. The sweeps drive every trigger code and the any-edge override across all 32 pins with several pad patterns, so each fault lands on a specific bit position.

// File: rtl/pin_port_irq.sv
module pin_port_irq #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:2]      bus_addr,
  input  logic            bus_we,
  input  logic [PINS-1:0] bus_wdata,
  output logic [PINS-1:0] bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic            irq_lo,
  output logic            irq_hi
);
  localparam int HALF = PINS / 2;
  localparam logic [2:0] A_DAT = 3'd0, A_DIR = 3'd1, A_PSR = 3'd2, A_CLO = 3'd3,
                         A_CHI = 3'd4, A_MSK = 3'd5, A_STS = 3'd6, A_ANY = 3'd7;

  logic [PINS-1:0] dat_q, dir_q, cfg_lo_q, cfg_hi_q, msk_q, sts_q, both_q;
  logic [PINS-1:0] s1_q, s2_q, prv_q, ev, clr;
  logic [2*PINS-1:0] cfg;

  assign cfg     = {cfg_hi_q, cfg_lo_q};
  assign pad_out = dat_q;
  assign pad_oe  = dir_q;
  assign clr     = (bus_we && bus_addr == A_STS) ? bus_wdata : '0;
  assign irq_lo  = |(sts_q[HALF-1:0] & msk_q[HALF-1:0]);
  assign irq_hi  = |(sts_q[PINS-1:HALF] & msk_q[PINS-1:HALF]);

  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      if (both_q[i]) ev[i] = s2_q[i] ^ prv_q[i];
      else begin
        case (cfg[2*i +: 2])
          2'b00:   ev[i] = ~s2_q[i];
          2'b01:   ev[i] = s2_q[i];
          2'b10:   ev[i] = s2_q[i] & ~prv_q[i];
          default: ev[i] = ~s2_q[i] & prv_q[i];
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DAT:   bus_rdata = dat_q;
      A_DIR:   bus_rdata = dir_q;
      A_PSR:   bus_rdata = s2_q;
      A_CLO:   bus_rdata = cfg_lo_q;
      A_CHI:   bus_rdata = cfg_hi_q;
      A_MSK:   bus_rdata = msk_q;
      A_STS:   bus_rdata = sts_q;
      default: bus_rdata = both_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= '0;
      s2_q  <= '0;
      prv_q <= '0;
      sts_q <= '0;
    end else begin
      s1_q  <= pad_in;
      s2_q  <= s1_q;
      prv_q <= s2_q;
      sts_q <= (sts_q & ~clr) | ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q    <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '0;
      cfg_hi_q <= '0;
      msk_q    <= '0;
      both_q   <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DAT:   dat_q    <= bus_wdata;
        A_DIR:   dir_q    <= bus_wdata;
        A_CLO:   cfg_lo_q <= bus_wdata;
        A_CHI:   cfg_hi_q <= bus_wdata;
        A_MSK:   msk_q    <= bus_wdata;
        A_ANY:   both_q   <= bus_wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pin_port_irq_chk.sv
module pin_port_irq_chk #(
  parameter int PINS = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [4:2]      bus_addr,
  input logic            bus_we,
  input logic [PINS-1:0] bus_wdata,
  input logic [PINS-1:0] pad_in,
  input logic [PINS-1:0] pad_oe,
  input logic            irq_lo,
  input logic            irq_hi,
  input logic [PINS-1:0] psr,
  input logic [PINS-1:0] sts,
  input logic [PINS-1:0] msk,
  input logic [PINS-1:0] both
);
  localparam int HALF = PINS / 2;
  logic [1:0] cnt;
  logic [PINS-1:0] psr_d, diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      psr_d <= '0;
    end else begin
      if (cnt != 2'd3) cnt <= cnt + 2'd1;
      psr_d <= psr;
    end
  end
  assign diff = (psr ^ psr_d) & both;

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == 3'd6) |=> ((sts & $past(sts)) == $past(sts)));
  a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd1) |=> (pad_oe == $past(bus_wdata)));
  a_r9_lo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (msk[HALF-1:0] == '0) |-> !irq_lo);
  a_r9_hi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (msk[PINS-1:HALF] == '0) |-> !irq_hi);
  a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 2'd2) |-> (psr == $past(pad_in, 2)));
  a_r6_any_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3) |=> ((sts & $past(diff)) == $past(diff)));
endmodule

bind pin_port_irq pin_port_irq_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pad_in(pad_in), .pad_oe(pad_oe),
  .irq_lo(irq_lo), .irq_hi(irq_hi), .psr(s2_q), .sts(sts_q),
  .msk(msk_q), .both(both_q)
);

// File: tb/sim_pin_port_irq.sv
`timescale 1ns/1ps
module sim_pin_port_irq;
  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0, irq_lo, irq_hi;
  logic [4:2] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pin_port_irq u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a[4:2]; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a[4:2];
    #1 d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] expect_sts(input logic [63:0] cfg, input logic [31:0] any,
                                             input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    for (int p = 0; p < 32; p++) begin
      if (any[p]) r[p] = a[p] ^ b[p];
      else case (cfg[2*p +: 2])
        2'b00:   r[p] = ~a[p] | ~b[p];
        2'b01:   r[p] = a[p] | b[p];
        2'b10:   r[p] = b[p] & ~a[p];
        default: r[p] = a[p] & ~b[p];
      endcase
    end
    return r;
  endfunction

  function automatic logic [31:0] level_only(input logic [63:0] cfg, input logic [31:0] any,
                                             input logic [31:0] b);
    logic [31:0] r;
    for (int p = 0; p < 32; p++) begin
      if (any[p]) r[p] = 1'b0;
      else case (cfg[2*p +: 2])
        2'b00:   r[p] = ~b[p];
        2'b01:   r[p] = b[p];
        default: r[p] = 1'b0;
      endcase
    end
    return r;
  endfunction

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, e, msk, any, a, b;
    logic [63:0] cfg;
    logic [31:0] pats [8];
    pats = '{32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0,
             32'hA5A5_0F0F, 32'h5A5A_00FF, 32'h1234_5678, 32'h8765_4321};
    cyc(3);
    @(negedge clk) rst_n = 1'b1;
    // R10 reset state
    rd(5'h00, r); chk("R10 data", r, 0);
    rd(5'h04, r); chk("R10 dir", r, 0);
    rd(5'h0C, r); chk("R10 cfg lo", r, 0);
    rd(5'h10, r); chk("R10 cfg hi", r, 0);
    rd(5'h14, r); chk("R10 enable", r, 0);
    rd(5'h1C, r); chk("R10 any-edge", r, 0);
    chk("R10 oe", pad_oe, 0);
    chk("R10 irq", {30'd0, irq_hi, irq_lo}, 0);

    // R1 / R2 readback and pad drive
    wr(5'h00, 32'hCAFE_1234); wr(5'h04, 32'h00FF_F00F);
    pad_in = 32'h1357_9BDF;
    cyc(3);
    rd(5'h00, r); chk("R1 data readback not pad", r, 32'hCAFE_1234);
    rd(5'h04, r); chk("R1 dir readback", r, 32'h00FF_F00F);
    chk("R2 pad_out", pad_out, 32'hCAFE_1234);
    chk("R2 pad_oe", pad_oe, 32'h00FF_F00F);
    wr(5'h14, 32'h0F0F_F0F0); rd(5'h14, r); chk("R1 enable readback", r, 32'h0F0F_F0F0);
    wr(5'h14, 32'h0);
    // R3 sync depth and write-ignore
    rd(5'h08, r); chk("R3 pad status", r, 32'h1357_9BDF);
    wr(5'h08, 32'h0); rd(5'h08, r); chk("R3 write ignored", r, 32'h1357_9BDF);
    @(negedge clk) pad_in = 32'h2468_ACE0;
    @(negedge clk); rd(5'h08, r); chk("R3 one edge old", r, 32'h1357_9BDF);
    @(negedge clk); rd(5'h08, r); chk("R3 two edges new", r, 32'h2468_ACE0);

    // R4 R5 edge timing on pin 21 rising
    pad_in = 32'h0;
    wr(5'h10, 32'h2 << 10); wr(5'h0C, 32'h5555_5555); wr(5'h1C, 32'h0);
    cyc(4); wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h18, r); chk("R5 cleared before edge", r & 32'h0020_0000, 0);
    pad_in = 32'h0020_0000;
    @(negedge clk); @(negedge clk); rd(5'h18, r); chk("R5 not yet after 2 edges", r & 32'h0020_0000, 0);
    @(negedge clk); rd(5'h18, r); chk("R5 set after 3rd edge", r & 32'h0020_0000, 32'h0020_0000);

    // R4 R5 R6 R7 R8 R9 sweep
    for (int rot = 0; rot < 4; rot++) begin
      for (int ai = 0; ai < 3; ai++) begin
        for (int pi = 0; pi < 4; pi++) begin
          any = (ai == 0) ? 32'h0 : (ai == 1) ? 32'hF0F0_3C3C : 32'hFFFF_FFFF;
          for (int p = 0; p < 32; p++) cfg[2*p +: 2] = 2'((p + rot) & 3);
          case ((rot + pi + ai) % 4)
            0: msk = 32'h0000_FFFF;
            1: msk = 32'hFFFF_0000;
            2: msk = 32'h8000_0001;
            default: msk = 32'hFFFF_FFFF;
          endcase
          a = pats[2*pi]; b = pats[2*pi+1];
          wr(5'h0C, cfg[31:0]); wr(5'h10, cfg[63:32]); wr(5'h1C, any); wr(5'h14, msk);
          pad_in = a;
          cyc(4);
          wr(5'h18, 32'hFFFF_FFFF);
          pad_in = b;
          cyc(4);
          e = expect_sts(cfg, any, a, b);
          rd(5'h18, r); chk("R4 R5 R6 status sweep", r, e);
          chk("R9 irq_lo", {31'd0, irq_lo}, {31'd0, |(e[15:0] & msk[15:0])});
          chk("R9 irq_hi", {31'd0, irq_hi}, {31'd0, |(e[31:16] & msk[31:16])});
          wr(5'h18, 32'h0);
          rd(5'h18, r); chk("R7 write zero keeps", r, e);
          wr(5'h18, 32'hFFFF_FFFF);
          rd(5'h18, r); chk("R7 R8 clear, levels reassert", r, level_only(cfg, any, b));
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule